// File: doc/BRIEF.md
# ECC-Protected Tag Comparator

This block decides whether a tag presented on a lookup matches a word read from a tag array that holds each tag as a systematic SEC-DED codeword. The stored word is never decoded. The incoming tag is encoded instead, and the block counts how many bit positions differ between the two codewords. That count selects one of four outcomes: identical, equal after a correctable repair, damaged beyond repair, or a genuine miss.

The stored word is systematic, so its data field is the tag itself. The data-field difference therefore starts at once from the raw tag. Parity generation runs beside it, and only the short parity-field difference waits for the encoder. Each field's difference vector feeds its own adder tree. A second stage sums the two partial counts, clips the sum, and classifies it.

The unit is purely combinational. A new tag/codeword pair may be applied on any cycle, and the verdict is valid in that same cycle. There is no handshake and no back-pressure: the surrounding lookup pipeline owns the timing. The default is an 8-bit tag in a 13-bit codeword, with one error correctable and two detectable.

Top module: `tagm_match`

## Requirements
- R1: The codeword has N = K + R + 1 bits, where R is the smallest integer with 2^R >= K + R + 1 (R = 4, N = 13 for K = 8). Bits [K-1:0] hold the tag unchanged. Tag bit i is given the i-th integer, counting up from 3, that is not a power of two. Bit K+j (j < R) is the XOR of the tag bits whose assigned integer has bit j set. Bit N-1 is the XOR of all other N-1 bits.
- R2: When the encoded incoming tag equals the stored word (distance 0), `hit_exact` is 1.
- R3: When the distance d satisfies 0 < d <= TMAX (default 1), `hit_fixable` is 1.
- R4: When TMAX < d <= RMAX (default RMAX = 2), `fault_uncorr` is 1.
- R5: When d > RMAX, `miss` is 1. This includes distances of 3 and the all-bits-flipped case.
- R6: For every input pair exactly one of the four outputs is 1.
- R7: Differences in the parity field [N-1:K] count toward d exactly as differences in the data field do. Errors confined to parity bits are therefore classified by their number alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tag_in | input | K | Incoming tag to look up |
| stored_cw | input | N | Codeword read from the tag array |
| hit_exact | output | 1 | Distance is zero |
| hit_fixable | output | 1 | Distance within correctable range |
| fault_uncorr | output | 1 | Detectable, uncorrectable damage |
| miss | output | 1 | Distance beyond detectable range |

## Verification
The two partial counts, one from the data field and one from the parity field, both contribute in the same evaluation whenever injected errors straddle the field boundary. The merged sum must then land in the correct range. This case is provoked by sweeping every error mask of up to three flipped bits, across both fields, against every 8-bit tag. The bench judges each verdict against a popcount of the mask, taken on an encoding it computes independently. Masks confined to the parity field separately show that parity-only damage is weighed like data damage.

// File: rtl/tagm_pkg.sv
package tagm_pkg;

  typedef enum logic [1:0] {
    CLS_EXACT   = 2'd0,
    CLS_FIXABLE = 2'd1,
    CLS_FAULT   = 2'd2,
    CLS_MISS    = 2'd3
  } match_cls_t;

  // Number of Hamming check bits for a k-bit payload.
  function automatic int ham_bits(input int k);
    int r;
    r = 0;
    while ((1 << r) < (k + r + 1)) r++;
    return r;
  endfunction

  // Hamming position (1-based) assigned to payload bit idx.
  function automatic int data_pos(input int idx);
    int pos;
    int seen;
    pos  = 3;
    seen = 0;
    while (1) begin
      if ((pos & (pos - 1)) != 0) begin
        if (seen == idx) return pos;
        seen++;
      end
      pos++;
    end
  endfunction

endpackage

// File: rtl/tagm_encoder.sv
module tagm_encoder #(
  parameter int K = 8,
  localparam int R = tagm_pkg::ham_bits(K),
  localparam int P = R + 1
) (
  input  logic [K-1:0] tag,
  output logic [P-1:0] parity
);

  function automatic logic [K-1:0] cover_mask(input int j);
    logic [K-1:0] m;
    m = '0;
    for (int i = 0; i < K; i++) begin
      m[i] = ((tagm_pkg::data_pos(i) >> j) & 1) != 0;
    end
    return m;
  endfunction

  logic [R-1:0] check;

  for (genvar j = 0; j < R; j++) begin : g_check
    localparam logic [K-1:0] MASK = cover_mask(j);
    assign check[j] = ^(tag & MASK);
  end

  assign parity = {(^tag) ^ (^check), check};

endmodule

// File: rtl/tagm_weight_count.sv
module tagm_weight_count #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1),
  localparam int LV = $clog2(W),
  localparam int PW = 1 << LV
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);

  logic [CW-1:0] node [1:2*PW-1];

  for (genvar i = 0; i < PW; i++) begin : g_leaf
    if (i < W) begin : g_used
      assign node[PW+i] = {{(CW-1){1'b0}}, bits[i]};
    end else begin : g_pad
      assign node[PW+i] = '0;
    end
  end

  for (genvar n = 1; n < PW; n++) begin : g_sum
    assign node[n] = node[2*n] + node[2*n+1];
  end

  assign count = node[1];

endmodule

// File: rtl/tagm_decide.sv
module tagm_decide #(
  parameter int DW   = 4,
  parameter int PW   = 3,
  parameter int TMAX = 1,
  parameter int RMAX = 2,
  localparam int SW  = ((DW > PW) ? DW : PW) + 1
) (
  input  logic [DW-1:0] data_cnt,
  input  logic [PW-1:0] par_cnt,
  output tagm_pkg::match_cls_t cls
);

  logic [SW-1:0] total;

  assign total = SW'(data_cnt) + SW'(par_cnt);

  always_comb begin
    if (total == '0)
      cls = tagm_pkg::CLS_EXACT;
    else if (32'(total) <= TMAX)
      cls = tagm_pkg::CLS_FIXABLE;
    else if (32'(total) <= RMAX)
      cls = tagm_pkg::CLS_FAULT;
    else
      cls = tagm_pkg::CLS_MISS;
  end

endmodule

// File: rtl/tagm_match.sv
module tagm_match #(
  parameter int K    = 8,
  parameter int TMAX = 1,
  parameter int RMAX = 2,
  localparam int R   = tagm_pkg::ham_bits(K),
  localparam int N   = K + R + 1
) (
  input  logic [K-1:0] tag_in,
  input  logic [N-1:0] stored_cw,
  output logic         hit_exact,
  output logic         hit_fixable,
  output logic         fault_uncorr,
  output logic         miss
);

  localparam int NP  = N - K;
  localparam int DCW = $clog2(K + 1);
  localparam int PCW = $clog2(NP + 1);

  logic [NP-1:0]  enc_par;
  logic [K-1:0]   diff_data;
  logic [NP-1:0]  diff_par;
  logic [DCW-1:0] cnt_data;
  logic [PCW-1:0] cnt_par;
  tagm_pkg::match_cls_t cls;

  // Data field compares straight from the raw tag.
  assign diff_data = tag_in ^ stored_cw[K-1:0];

  tagm_encoder #(.K(K)) u_enc (
    .tag    (tag_in),
    .parity (enc_par)
  );

  assign diff_par = enc_par ^ stored_cw[N-1:K];

  tagm_weight_count #(.W(K)) u_cnt_data (
    .bits  (diff_data),
    .count (cnt_data)
  );

  tagm_weight_count #(.W(NP)) u_cnt_par (
    .bits  (diff_par),
    .count (cnt_par)
  );

  tagm_decide #(.DW(DCW), .PW(PCW), .TMAX(TMAX), .RMAX(RMAX)) u_dec (
    .data_cnt (cnt_data),
    .par_cnt  (cnt_par),
    .cls      (cls)
  );

  assign hit_exact    = (cls == tagm_pkg::CLS_EXACT);
  assign hit_fixable  = (cls == tagm_pkg::CLS_FIXABLE);
  assign fault_uncorr = (cls == tagm_pkg::CLS_FAULT);
  assign miss         = (cls == tagm_pkg::CLS_MISS);

endmodule

// File: rtl/tagm_match_chk.sv
module tagm_match_chk #(
  parameter int K    = 8,
  parameter int TMAX = 1,
  parameter int RMAX = 2,
  localparam int R   = tagm_pkg::ham_bits(K),
  localparam int N   = K + R + 1
) (
  input logic [K-1:0] tag_in,
  input logic [N-1:0] stored_cw,
  input logic         hit_exact,
  input logic         hit_fixable,
  input logic         fault_uncorr,
  input logic         miss
);

  always_comb begin
    a_r6_one_verdict: assert ($countones({hit_exact, hit_fixable, fault_uncorr, miss}) == 1)
      else $error("R6: verdict flags not one-hot");
    a_r2_exact_data_equal: assert (!hit_exact || (stored_cw[K-1:0] == tag_in))
      else $error("R2: exact verdict with differing data field");
    a_r3_fix_data_bound: assert (!(hit_exact || hit_fixable)
                                 || ($countones(stored_cw[K-1:0] ^ tag_in) <= TMAX))
      else $error("R3: hit verdict despite too many data differences");
    a_r5_data_far_miss: assert (($countones(stored_cw[K-1:0] ^ tag_in) <= RMAX) || miss)
      else $error("R5: data field alone beyond range but no miss");
  end

endmodule

bind tagm_match tagm_match_chk #(.K(K), .TMAX(TMAX), .RMAX(RMAX)) u_chk (
  .tag_in       (tag_in),
  .stored_cw    (stored_cw),
  .hit_exact    (hit_exact),
  .hit_fixable  (hit_fixable),
  .fault_uncorr (fault_uncorr),
  .miss         (miss)
);

// File: tb/tagm_match_test.sv
module tagm_match_test;

  localparam int K = 8;
  localparam int N = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [K-1:0] tag_in = '0;
  logic [N-1:0] stored_cw = '0;
  logic hit_exact, hit_fixable, fault_uncorr, miss;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  tagm_match #(.K(K), .TMAX(1), .RMAX(2)) uut (
    .tag_in       (tag_in),
    .stored_cw    (stored_cw),
    .hit_exact    (hit_exact),
    .hit_fixable  (hit_fixable),
    .fault_uncorr (fault_uncorr),
    .miss         (miss)
  );

  // Encoding per R1, computed from the stated positions.
  function automatic logic [N-1:0] ref_encode(input logic [K-1:0] t);
    logic [3:0] chk;
    int pos;
    chk = '0;
    pos = 3;
    for (int i = 0; i < K; i++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      for (int j = 0; j < 4; j++)
        if (((pos >> j) & 1) != 0) chk[j] = chk[j] ^ t[i];
      pos++;
    end
    return {(^t) ^ (^chk), chk, t};
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s tag=%h cw=%h got=%b expected=%b", req, tag_in, stored_cw, got, exp);
    end
  endtask

  task automatic apply(input logic [K-1:0] t, input logic [N-1:0] err);
    int d;
    logic [3:0] exp;
    string req;
    tag_in    = t;
    stored_cw = ref_encode(t) ^ err;
    #2;
    d = $countones(err);
    if (d == 0)      begin exp = 4'b1000; req = "R1 R2"; end
    else if (d <= 1) begin exp = 4'b0100; req = "R3"; end
    else if (d <= 2) begin exp = 4'b0010; req = "R4"; end
    else             begin exp = 4'b0001; req = "R5"; end
    if (d != 0 && err[K-1:0] == '0) req = {req, " R7"};
    check(req, {hit_exact, hit_fixable, fault_uncorr, miss}, exp);
    n_checks++;
    if ($countones({hit_exact, hit_fixable, fault_uncorr, miss}) != 1) begin
      n_fails++;
      $display("FAIL R6 tag=%h got=%b expected=one-hot", t,
               {hit_exact, hit_fixable, fault_uncorr, miss});
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 100000) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset-state check: all-zero tag against all-zero word is exact (R2).
    check("R2 reset", {hit_exact, hit_fixable, fault_uncorr, miss}, 4'b1000);
    // Directed: parity-only errors (R7).
    apply(8'hA5, 13'h0100);
    apply(8'hA5, 13'h1800);
    apply(8'h3C, 13'h1F00);
    // Sweep every tag against every mask of up to three flips, plus all-ones.
    for (int t = 0; t < 256; t++) begin
      for (int m = 0; m < 8192; m++) begin
        if ($countones(m) <= 3 || m == 8191)
          apply(K'(t), N'(m));
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule